// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block holds a bank of general-purpose words for a processor datapath. Two operand indices are looked up at the same time, with no clock involved, so the instruction decoder can fetch both source operands in one cycle. A single destination word is written back per cycle, and that write is committed on the falling clock edge. Because of this, a result written back in a cycle can already be read by the operand lookup during the low phase of that same cycle. The next rising edge then captures the new value.

Entry zero is hard-wired. It always reads as zero, and any write aimed at it is dropped, which gives the instruction set a constant-zero source and a discard destination. A synchronous clear input, which can be left out with a parameter, zeroes every entry on a falling edge. The block has no state machine. It has one storage element per entry, a write decoder and two read multiplexers.

Top module: `regfile_2r1w`

## Requirements
- R1: After a write with `wr_en` high to index n (n from 1 to 31), either read port given index n returns the written 32-bit word until that entry is written again or cleared.
- R2: A write is committed on the falling edge of `clk`. The new value appears on a read port addressing that entry before the following rising edge.
- R3: When `wr_en` is low at a falling edge, no entry changes, whatever `wr_idx` and `wr_data` hold.
- R4: Reading index 0 on either port always returns 32'h0000_0000. A write with `wr_en` high to index 0 changes nothing.
- R5: The two read ports are independent and combinational. Each returns the entry selected by its own 5-bit index, including when both indices are equal.
- R6: When `clr` is high at a falling edge, every entry becomes zero. This takes precedence over a write presented at the same edge.
- R7: A write to one index leaves every other entry unchanged.
- R8: Between a rising edge and the next falling edge, a read of the entry being written still returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and clear act on its falling edge |
| clr | input | 1 | Synchronous clear of all entries, active high |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Index of the entry to write |
| wr_data | input | 32 | Word to write |
| rd_idx_a | input | 5 | Index for read port A |
| rd_idx_b | input | 5 | Index for read port B |
| rd_data_a | output | 32 | Word at `rd_idx_a` |
| rd_data_b | output | 32 | Word at `rd_idx_b` |

## Verification
The hardest case to reach from the ports is telling the two halves of one cycle apart. The old word must still be visible after the rising edge, and the new word must be visible after the falling edge, within one clock period. The stimulus therefore changes inputs just after each rising edge. It samples both read ports twice per cycle, once in the high phase and once in the low phase, and compares each sample against a reference model taken before and after the write. Writes to the same entry in consecutive cycles, clears that coincide with writes, and writes to entry zero are all driven through this same two-sample check.

// File: rtl/rf_pkg.sv
package rf_pkg;

    // Default geometry of the register bank
    localparam int RF_WORD_BITS = 32;
    localparam int RF_ENTRIES   = 32;

    // Selects whether the bank carries a synchronous clear
    typedef enum logic {
        RF_NO_CLEAR   = 1'b0,
        RF_WITH_CLEAR = 1'b1
    } rf_clear_mode_e;

    localparam rf_clear_mode_e RF_CLEAR_DEFAULT = RF_WITH_CLEAR;

endpackage

// File: rtl/rf_wr_decode.sv
// Turns the write index and enable into per-entry strobes.
// Entry 0 has no strobe: writes aimed there are dropped.
module rf_wr_decode #(
    parameter int ENTRIES = rf_pkg::RF_ENTRIES,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    output logic [ENTRIES-1:1] row_strobe
);

    for (genvar r = 1; r < ENTRIES; r++) begin : g_strobe
        assign row_strobe[r] = wr_en && (wr_idx == IDX_W'(r));
    end

endmodule

// File: rtl/rf_storage.sv
// One word register per entry, updated on the falling clock edge.
// Entry 0 is a constant zero and holds no flops.
module rf_storage #(
    parameter int                     ENTRIES = rf_pkg::RF_ENTRIES,
    parameter int                     WORD_W  = rf_pkg::RF_WORD_BITS,
    parameter rf_pkg::rf_clear_mode_e CLEAR   = rf_pkg::RF_CLEAR_DEFAULT
) (
    input  logic                           clk,
    input  logic                           clr,
    input  logic [ENTRIES-1:1]             row_strobe,
    input  logic [WORD_W-1:0]              wr_data,
    output logic [ENTRIES-1:0][WORD_W-1:0] rows
);

    assign rows[0] = '0;

    for (genvar r = 1; r < ENTRIES; r++) begin : g_row
        logic [WORD_W-1:0] q;

        if (CLEAR == rf_pkg::RF_WITH_CLEAR) begin : g_clr
            always_ff @(negedge clk) begin
                if (clr) begin
                    q <= '0;
                end else if (row_strobe[r]) begin
                    q <= wr_data;
                end
            end
        end else begin : g_noclr
            always_ff @(negedge clk) begin
                if (row_strobe[r]) begin
                    q <= wr_data;
                end
            end
        end

        assign rows[r] = q;
    end

endmodule

// File: rtl/rf_read_port.sv
// Combinational word selection for one read port.
module rf_read_port #(
    parameter int ENTRIES = rf_pkg::RF_ENTRIES,
    parameter int WORD_W  = rf_pkg::RF_WORD_BITS,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0][WORD_W-1:0] rows,
    input  logic [IDX_W-1:0]               rd_idx,
    output logic [WORD_W-1:0]              rd_data
);

    localparam int SPAN = 1 << IDX_W;

    if (ENTRIES == SPAN) begin : g_full
        // Every index value names an entry
        always_comb begin
            rd_data = rows[rd_idx];
        end
    end else begin : g_partial
        // Indices past the last entry read as zero
        always_comb begin
            rd_data = '0;
            for (int e = 0; e < ENTRIES; e++) begin
                if (rd_idx == IDX_W'(e)) begin
                    rd_data = rows[e];
                end
            end
        end
    end

endmodule

// File: rtl/regfile_2r1w.sv
// Register bank: two combinational read ports, one falling-edge write port.
module regfile_2r1w #(
    parameter int                     ENTRIES = rf_pkg::RF_ENTRIES,
    parameter int                     WORD_W  = rf_pkg::RF_WORD_BITS,
    parameter rf_pkg::rf_clear_mode_e CLEAR   = rf_pkg::RF_CLEAR_DEFAULT,
    parameter int                     IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx_a,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output logic [WORD_W-1:0] rd_data_a,
    output logic [WORD_W-1:0] rd_data_b
);

    logic [ENTRIES-1:1]             row_strobe;
    logic [ENTRIES-1:0][WORD_W-1:0] rows;

    rf_wr_decode #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_dec (
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .row_strobe (row_strobe)
    );

    rf_storage #(
        .ENTRIES (ENTRIES),
        .WORD_W  (WORD_W),
        .CLEAR   (CLEAR)
    ) u_bank (
        .clk        (clk),
        .clr        (clr),
        .row_strobe (row_strobe),
        .wr_data    (wr_data),
        .rows       (rows)
    );

    rf_read_port #(
        .ENTRIES (ENTRIES),
        .WORD_W  (WORD_W),
        .IDX_W   (IDX_W)
    ) u_rd_a (
        .rows    (rows),
        .rd_idx  (rd_idx_a),
        .rd_data (rd_data_a)
    );

    rf_read_port #(
        .ENTRIES (ENTRIES),
        .WORD_W  (WORD_W),
        .IDX_W   (IDX_W)
    ) u_rd_b (
        .rows    (rows),
        .rd_idx  (rd_idx_b),
        .rd_data (rd_data_b)
    );

endmodule

// File: rtl/rf_chk.sv
// Property checker for regfile_2r1w, attached with bind below.
module rf_chk #(
    parameter int WORD_W    = 32,
    parameter int IDX_W     = 5,
    parameter bit HAS_CLEAR = 1'b1
) (
    input logic              clk,
    input logic              clr,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [WORD_W-1:0] wr_data,
    input logic [IDX_W-1:0]  rd_idx_a,
    input logic [IDX_W-1:0]  rd_idx_b,
    input logic [WORD_W-1:0] rd_data_a,
    input logic [WORD_W-1:0] rd_data_b
);

    // Snapshot of what the last falling edge did
    logic              cap_valid = 1'b0;
    logic              cap_wr;
    logic              cap_clr;
    logic [IDX_W-1:0]  cap_idx;
    logic [WORD_W-1:0] cap_data;
    logic              seen_rise = 1'b0;

    always_ff @(negedge clk) begin
        cap_valid <= 1'b1;
        cap_wr    <= wr_en && (wr_idx != '0);
        cap_clr   <= HAS_CLEAR && clr;
        cap_idx   <= wr_idx;
        cap_data  <= wr_data;
    end

    always_ff @(posedge clk) begin
        seen_rise <= cap_valid;
    end

    // R4
    zero_idx_a_chk: assert property (@(posedge clk) disable iff (clr)
        (rd_idx_a == '0) |-> (rd_data_a == '0));

    // R4
    zero_idx_b_chk: assert property (@(posedge clk) disable iff (clr)
        (rd_idx_b == '0) |-> (rd_data_b == '0));

    // R2
    fresh_write_a_chk: assert property (@(posedge clk) disable iff (clr)
        (cap_valid && cap_wr && !cap_clr && rd_idx_a == cap_idx)
            |-> (rd_data_a == cap_data));

    // R2
    fresh_write_b_chk: assert property (@(posedge clk) disable iff (clr)
        (cap_valid && cap_wr && !cap_clr && rd_idx_b == cap_idx)
            |-> (rd_data_b == cap_data));

    // R7
    untouched_a_chk: assert property (@(posedge clk) disable iff (clr)
        (seen_rise && !cap_clr && $stable(rd_idx_a)
            && !(cap_wr && cap_idx == rd_idx_a)) |-> $stable(rd_data_a));

    // R6
    cleared_chk: assert property (@(posedge clk) disable iff (!cap_valid)
        cap_clr |-> (rd_data_a == '0 && rd_data_b == '0));

endmodule

bind regfile_2r1w rf_chk #(
    .WORD_W    (WORD_W),
    .IDX_W     (IDX_W),
    .HAS_CLEAR (CLEAR == rf_pkg::RF_WITH_CLEAR)
) u_rf_chk (
    .clk       (clk),
    .clr       (clr),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx_a  (rd_idx_a),
    .rd_idx_b  (rd_idx_b),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b)
);

// File: tb/tb_regfile_2r1w.sv
module tb_regfile_2r1w;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b1;
    logic        clr = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_idx_a = '0;
    logic [4:0]  rd_idx_b = '0;
    logic [31:0] rd_data_a;
    logic [31:0] rd_data_b;

    regfile_2r1w dut (
        .clk       (clk),
        .clr       (clr),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx_a  (rd_idx_a),
        .rd_idx_b  (rd_idx_b),
        .rd_data_a (rd_data_a),
        .rd_data_b (rd_data_b)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        string       req;
        bit          check_pre;
        logic [31:0] pre_a;
        logic [31:0] pre_b;
        logic [31:0] post_a;
        logic [31:0] post_b;
    } item_t;

    item_t       sb[$];
    logic [31:0] mdl [32];
    int          n_vec  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;

    task automatic compare(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected reads
    task automatic step(input bit c, input bit we, input logic [4:0] wi,
                        input logic [31:0] wd, input logic [4:0] ia,
                        input logic [4:0] ib, input bit chk_pre,
                        input string req);
        item_t it;
        @(posedge clk);
        #1;
        clr = c; wr_en = we; wr_idx = wi; wr_data = wd;
        rd_idx_a = ia; rd_idx_b = ib;
        it.req       = req;
        it.check_pre = chk_pre;
        it.pre_a     = mdl[ia];
        it.pre_b     = mdl[ib];
        if (c) begin
            for (int k = 0; k < 32; k++) mdl[k] = '0;
        end else if (we && wi != 5'd0) begin
            mdl[wi] = wd;
        end
        it.post_a = mdl[ia];
        it.post_b = mdl[ib];
        sb.push_back(it);
    endtask

    // Monitor: high-phase and low-phase samples of both ports
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                it = sb[0];
                if (it.check_pre) begin
                    compare({it.req, " R8"}, "port A before fall", rd_data_a, it.pre_a);
                    compare({it.req, " R8"}, "port B before fall", rd_data_b, it.pre_b);
                end
                @(negedge clk);
                #2;
                compare(it.req, "port A after fall", rd_data_a, it.post_a);
                compare(it.req, "port B after fall", rd_data_b, it.post_b);
                void'(sb.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 32; k++) mdl[k] = 'x;
        // R6 reset state: clear, then read corners
        step(1, 0, 0, 0, 0, 31, 0, "R6");
        step(1, 0, 0, 0, 1, 17, 1, "R6");
        step(0, 0, 0, 0, 31, 30, 1, "R6");
        // R1 R2 basic write, same-cycle visibility on both ports
        step(0, 1, 5, 32'hA5A5_5A5A, 5, 5, 1, "R1 R2");
        // R5 independent ports
        step(0, 1, 31, 32'hDEAD_BEEF, 31, 5, 1, "R5");
        // R4 write to entry zero is dropped
        step(0, 1, 0, 32'hFFFF_FFFF, 0, 0, 1, "R4");
        step(0, 0, 0, 0, 0, 5, 1, "R4");
        // R3 enable low leaves entry unchanged
        step(0, 0, 5, 32'h1234_5678, 5, 31, 1, "R3");
        // R7 neighbour write does not disturb
        step(0, 1, 6, 32'h0F0F_0F0F, 5, 6, 1, "R7");
        // R8 consecutive writes to one entry
        step(0, 1, 9, 32'h1111_1111, 9, 9, 1, "R8");
        step(0, 1, 9, 32'h2222_2222, 9, 0, 1, "R8");
        step(0, 1, 9, 32'h3333_3333, 9, 6, 1, "R8");
        // R1 R2 fill every entry, reading it and its neighbour
        for (int i = 1; i < 32; i++) begin
            step(0, 1, 5'(i), (32'(i) * 32'h0101_0101) ^ 32'hC300_00C3,
                 5'(i), 5'(i - 1), 1, "R1 R2");
        end
        // R5 R7 read sweep with no writes
        for (int i = 0; i < 32; i++) begin
            step(0, 0, 5'(i), 32'hFFFF_0000, 5'(i), 5'(31 - i), 1, "R5 R7");
        end
        // R6 clear wins over a simultaneous write
        step(1, 1, 12, 32'hBADC_0FFE, 12, 31, 1, "R6");
        step(0, 0, 0, 0, 12, 3, 1, "R6");
        step(0, 1, 3, 32'h0000_0001, 3, 12, 1, "R1 R6");
        step(0, 0, 0, 0, 3, 3, 1, "R1");
        wait (sb.size() == 0);
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule